// File: doc/BRIEF.md
# Sign-Extending Conversion Result FIFO

This block sits between a 12-bit analog-to-digital converter and a host read port. Each finished conversion is pushed in with a one-cycle write strobe. The converter can start its next conversion at once, and the host can fall up to sixteen samples behind before anything is lost. Every sample is a 12-bit two's-complement value from -2048 to 2047. It is sign-extended to 16 bits on entry, so the host always reads a 16-bit word.

A data-available flag shows whether at least one result is waiting. A sticky overflow flag records that a conversion arrived while all sixteen places were taken and the buffer could not make room. That conversion is dropped and the stored samples stay as they were. A synchronous clear empties the buffer and drops the overflow flag.

Top module: `adc_result_fifo`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `data_avail` and `ovf_err` are 0 and `rd_word` is 16'h0000.
- R2: A stored sample s reads back with bits [11:0] equal to s and bits [15:12] all equal to bit 11 of s. For example, 12'h800 reads as 16'hF800 and 12'h7FF reads as 16'h07FF.
- R3: Samples are read in the order they were written. A read strobe on a non-empty buffer puts the oldest sample on `rd_word` in the cycle after the strobe, and `rd_word` holds that value until the next accepted read.
- R4: Sixteen writes with no reads in between are all stored and do not set `ovf_err`.
- R5: A write strobe with no read strobe, no clear and sixteen samples held sets `ovf_err` in the next cycle. The sample is discarded and the sixteen stored samples read back unchanged.
- R6: Once set, `ovf_err` stays 1 through reads and writes until a clear or reset.
- R7: `clr` empties the buffer and clears `ovf_err` in the next cycle. A write or read strobe in the same cycle as `clr` is ignored, and `rd_word` keeps its value.
- R8: A read strobe and a write strobe together on a full buffer are both accepted. `ovf_err` does not rise and the buffer stays full.
- R9: A read strobe on an empty buffer leaves `rd_word` unchanged and moves no pointer. A later write followed by a read returns that written sample.
- R10: `data_avail` is 1 exactly when at least one sample is held, updated in the cycle after the strobe that changes the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one conversion result |
| wr_sample | input | 12 | Two's-complement conversion result |
| rd_en | input | 1 | Read strobe from the host |
| clr | input | 1 | Synchronous clear of buffer and overflow flag |
| rd_word | output | 16 | Sign-extended sample returned by the last accepted read |
| data_avail | output | 1 | Status: at least one sample held |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The bench goes after the full-buffer edge. A seventeenth write must set the error without overwriting the oldest sample; a design that wrapped its write pointer would return the new sample in place of the first one. A combined read and write on a full buffer must not raise the error, and a design that checked fullness before the read would flag a false overflow there. Reads on an empty buffer and a clear that comes with strobes are also driven: a design that got these wrong would move a pointer, output stale memory or keep a sample. Negative extremes such as 12'h800 show any sign-extension mistake as wrong upper bits.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = 16;
  localparam int DEPTH    = 16;
endpackage

// File: rtl/sxf_sext.sv
module sxf_sext #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_same
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sxf_ctrl.sv
module sxf_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          clr,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count_q,
  output logic          ovf_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_d;
  logic          ovf_d;

  always_comb begin
    rd_ok    = rd_en && !clr && (count_q != '0);
    wr_ok    = wr_en && !clr && ((count_q != FULL_CNT) || rd_ok);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    ovf_d    = ovf_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
      ovf_d    = 1'b0;
    end else begin
      if (wr_ok) begin
        wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + AW'(1);
      end
      if (rd_ok) begin
        rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + AW'(1);
      end
      count_d = count_q + CW'(wr_ok) - CW'(rd_ok);
      if (wr_en && !wr_ok) begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
endmodule

// File: rtl/sxf_store.sv
module sxf_store #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata_q
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) begin
      rdata_d = mem[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
  import sxf_pkg::*;
#(
  parameter int IN_W  = SAMPLE_W,
  parameter int OUT_W = WORD_W,
  parameter int NENT  = DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  wr_sample,
  input  logic             rd_en,
  input  logic             clr,
  output logic [OUT_W-1:0] rd_word,
  output logic             data_avail,
  output logic             ovf_err
);
  localparam int AW = $clog2(NENT);
  localparam int CW = AW + 1;

  logic [OUT_W-1:0] wide_sample;
  logic             wr_ok, rd_ok;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count_q;

  sxf_sext #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sext (
    .din  (wr_sample),
    .dout (wide_sample)
  );

  sxf_ctrl #(.DEPTH(NENT), .AW(AW), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .clr     (clr),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .count_q (count_q),
    .ovf_q   (ovf_err)
  );

  sxf_store #(.W(OUT_W), .DEPTH(NENT), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_ok),
    .waddr   (wr_ptr),
    .wdata   (wide_sample),
    .re      (rd_ok),
    .raddr   (rd_ptr),
    .rdata_q (rd_word)
  );

  assign data_avail = (count_q != '0);
endmodule

// File: rtl/adc_result_fifo_chk.sv
module adc_result_fifo_chk #(
  parameter int OUT_W = 16,
  parameter int NENT  = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             clr,
  input logic [OUT_W-1:0] rd_word,
  input logic             data_avail,
  input logic             ovf_err,
  input logic [CW-1:0]    count_q
);
  assert_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[OUT_W-1:11] == '0) || (rd_word[OUT_W-1:11] == '1));

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(NENT));

  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(wr_en && !rd_en && !clr));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !clr) |=> ovf_err);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ovf_err && !data_avail && $stable(rd_word)));

  assert_rdwr_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !clr) |=> $stable(ovf_err));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_avail) |=> $stable(rd_word));
endmodule

bind adc_result_fifo adc_result_fifo_chk #(.OUT_W(OUT_W), .NENT(NENT), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .clr        (clr),
  .rd_word    (rd_word),
  .data_avail (data_avail),
  .ovf_err    (ovf_err),
  .count_q    (count_q)
);

// File: tb/sim_adc_result_fifo.sv
module sim_adc_result_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_sample = '0;
  logic        rd_en = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] rd_word;
  logic        data_avail;
  logic        ovf_err;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  logic [15:0] mq[$];
  logic [15:0] m_word = '0;
  bit          m_ovf = 0;

  always #4 clk = ~clk;

  adc_result_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sample(wr_sample),
    .rd_en(rd_en), .clr(clr), .rd_word(rd_word),
    .data_avail(data_avail), .ovf_err(ovf_err)
  );

  function automatic logic [15:0] sext(input logic [11:0] s);
    return {{4{s[11]}}, s};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_word = '0;
      m_ovf  = 0;
    end else if (clr) begin
      mq.delete();
      m_ovf = 0;
    end else begin
      bit r_ok, w_ok;
      r_ok = rd_en && (mq.size() > 0);
      w_ok = wr_en && ((mq.size() < 16) || r_ok);
      if (r_ok) m_word = mq.pop_front();
      if (wr_en && !w_ok) m_ovf = 1;
      if (w_ok) mq.push_back(sext(wr_sample));
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", rd_word, m_word);
      chk("R10", {15'd0, data_avail}, {15'd0, mq.size() > 0});
      chk("R6", {15'd0, ovf_err}, {15'd0, m_ovf});
    end
  end

  task automatic cyc(input bit w, input logic [11:0] d, input bit r, input bit c);
    wr_en = w; wr_sample = d; rd_en = r; clr = c;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; clr = 0;
  endtask

  initial begin
    #50000000;
    bad++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rd_word, 16'h0000);
    chk("R1", {15'd0, data_avail}, 16'd0);
    chk("R1", {15'd0, ovf_err}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {14'd0, data_avail, ovf_err}, 16'd0);

    // R2: sign extension extremes
    cyc(1, 12'h800, 0, 0);
    cyc(1, 12'h7FF, 0, 0);
    cyc(1, 12'hFFF, 0, 0);
    cyc(0, 0, 1, 0); chk("R2", rd_word, 16'hF800);
    cyc(0, 0, 1, 0); chk("R2", rd_word, 16'h07FF);
    cyc(0, 0, 1, 0); chk("R2", rd_word, 16'hFFFF);
    chk("R10", {15'd0, data_avail}, 16'd0);

    // R9: read on empty holds output
    cyc(0, 0, 1, 0); chk("R9", rd_word, 16'hFFFF);
    cyc(1, 12'h123, 1, 0); chk("R9", rd_word, 16'hFFFF);
    cyc(0, 0, 1, 0); chk("R9", rd_word, 16'h0123);

    // R4: sixteen writes, no overflow
    for (int i = 0; i < 16; i++) cyc(1, 12'(i * 37 + 5), 0, 0);
    chk("R4", {15'd0, ovf_err}, 16'd0);
    chk("R4", {15'd0, data_avail}, 16'd1);
    // R5: seventeenth write overflows and is dropped
    cyc(1, 12'hABC, 0, 0);
    chk("R5", {15'd0, ovf_err}, 16'd1);
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 1, 0);
      chk("R5", rd_word, sext(12'(i * 37 + 5)));
    end
    chk("R5", {15'd0, data_avail}, 16'd0);
    chk("R6", {15'd0, ovf_err}, 16'd1);
    cyc(1, 12'h055, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R6", {15'd0, ovf_err}, 16'd1);

    // R7: clear drops flag, empties, ignores strobes
    cyc(1, 12'h321, 0, 0);
    cyc(1, 12'h444, 1, 1);
    chk("R7", {15'd0, ovf_err}, 16'd0);
    chk("R7", {15'd0, data_avail}, 16'd0);
    chk("R7", rd_word, 16'h0055);

    // R8: read and write together on full buffer
    for (int i = 0; i < 16; i++) cyc(1, 12'(i + 100), 0, 0);
    cyc(1, 12'h9AA, 1, 0);
    chk("R8", {15'd0, ovf_err}, 16'd0);
    chk("R8", rd_word, 16'd100);
    cyc(1, 12'h9AB, 0, 0);
    chk("R8", {15'd0, ovf_err}, 16'd1);
    cyc(0, 0, 0, 1);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int p;
      p = $urandom_range(0, 99);
      cyc(p < 55, 12'($urandom), ($urandom_range(0, 99) < 45), p == 99);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule